// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry step of exception handling for a small 32-bit processor that has several operating modes. Seven request lines can raise an exception: a reset request, an undefined instruction, a software interrupt, a prefetch abort, a data abort, a normal interrupt and a fast interrupt. In any cycle the block picks the winning request, taking into account a fixed priority and the two interrupt-disable bits of the current status word. It then drives one cycle of register-file write strobes. These strobes save the old status word into the target mode's saved-status register, load the target mode's banked link register with the return address, write a new status word, force the program counter to the exception's slot in a fixed vector table and pulse a flush to the fetch pipeline.

The program counter input is the architectural value, which runs two instructions (8 bytes) ahead of the instruction that was executing. The return address is derived from that value. Each entry produces one registered burst of strobes. During the cycle in which those strobes are visible, the core has not yet absorbed them, so the block ignores every request in that cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: One clock edge after a request is accepted, `pc_we` is high for one cycle and `pc_data` holds the vector. The vectors are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18 and fast interrupt 0x1C. Address 0x14 is reserved and is never produced.
- R2: The target mode appears on `new_mode` together with the strobes and holds until the next entry. Mode codes: fast interrupt 0x11, interrupt 0x12, supervisor 0x13 (reset and software interrupt), abort 0x17 (both aborts), undefined 0x1B.
- R3: Every entry other than reset raises `sav_we`, sets `sav_mode` to the target mode and sets `sav_data` to the sampled status word with its bits [4:0] replaced by the sampled `cur_mode`.
- R4: Every entry other than reset raises `lnk_we` with `lnk_mode` equal to the target mode. `lnk_data` is `cur_pc` - 4, except for a data abort, where it is `cur_pc`.
- R5: When several requests are accepted together, one wins in this order: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R6: An interrupt request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1. A masked request neither produces strobes nor blocks a lower request.
- R7: On entry, `sts_we` is high and `sts_data` is the sampled status word with these changes: bits [4:0] become the target mode, bit 5 is cleared and bit 7 is set. Bit 6 is set for a fast interrupt and keeps its sampled value for the other kinds.
- R8: A reset request enters supervisor mode at 0x00. It raises neither `sav_we` nor `lnk_we`, and `sts_data` is 0x000000D3.
- R9: `flush` pulses for exactly the cycle in which `pc_we` is high. Requests present in that cycle are ignored, so a held request enters again only in the following cycle.
- R10: While reset is asserted and after it is released, with no request, every strobe and `flush` are low and `new_mode` is 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_pc | input | 32 | Architectural PC (executing address + 8) |
| cur_status | input | 32 | Current status word |
| cur_mode | input | 5 | Current mode code |
| pc_we | output | 1 | PC write strobe |
| pc_data | output | 32 | Vector address |
| sts_we | output | 1 | Status word write strobe |
| sts_data | output | 32 | New status word |
| sav_we | output | 1 | Saved-status register write strobe |
| sav_mode | output | 5 | Mode whose saved-status register is written |
| sav_data | output | 32 | Status word to save |
| lnk_we | output | 1 | Banked link register write strobe |
| lnk_mode | output | 5 | Mode whose link register is written |
| lnk_data | output | 32 | Return address |
| new_mode | output | 5 | Mode after entry |
| flush | output | 1 | One-cycle fetch pipeline flush |

## Verification
The hardest situation to reach is the hold-off cycle. A request that is still present while the previous entry's strobes are visible must produce nothing, and it must then be taken one cycle later. The stimulus holds an interrupt request for three consecutive cycles and checks entry, silence and entry again. A second hard case is a masked fast interrupt that sits above an unmasked interrupt. The stimulus builds it by raising both requests with only status bit 6 set, then checks that the lower interrupt wins.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int MODE_W  = 5;
  localparam int NUM_SRC = 7;

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

  // status word bit positions
  localparam int ST_T = 5;
  localparam int ST_F = 6;
  localparam int ST_I = 7;

  // priority slots, 0 is highest
  localparam int PRI_RST  = 0;
  localparam int PRI_DABT = 1;
  localparam int PRI_FIQ  = 2;
  localparam int PRI_IRQ  = 3;
  localparam int PRI_PABT = 4;
  localparam int PRI_UND  = 5;
  localparam int PRI_SWI  = 6;

  // encoding equals vector slot index
  typedef enum logic [2:0] {
    EX_RESET = 3'd0,
    EX_UNDEF = 3'd1,
    EX_SWI   = 3'd2,
    EX_PABT  = 3'd3,
    EX_DABT  = 3'd4,
    EX_RSVD  = 3'd5,
    EX_IRQ   = 3'd6,
    EX_FIQ   = 3'd7
  } exc_kind_e;

  function automatic exc_kind_e slot_kind(input int idx);
    exc_kind_e k;
    case (idx)
      PRI_RST:  k = EX_RESET;
      PRI_DABT: k = EX_DABT;
      PRI_FIQ:  k = EX_FIQ;
      PRI_IRQ:  k = EX_IRQ;
      PRI_PABT: k = EX_PABT;
      PRI_UND:  k = EX_UNDEF;
      default:  k = EX_SWI;
    endcase
    return k;
  endfunction

  function automatic logic [MODE_W-1:0] kind_mode(input exc_kind_e k);
    logic [MODE_W-1:0] m;
    case (k)
      EX_UNDEF:        m = MD_UND;
      EX_PABT, EX_DABT: m = MD_ABT;
      EX_IRQ:          m = MD_IRQ;
      EX_FIQ:          m = MD_FIQ;
      default:         m = MD_SVC;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_q,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               irq_off,
  input  logic               fiq_off,
  input  logic               busy,
  output logic               take,
  output exc_kind_e          kind
);

  logic [NUM_SRC-1:0] qual;
  logic [NUM_SRC-1:0] grant;

  // masking and hold-off
  always_comb begin
    qual           = src_req;
    qual[PRI_FIQ]  = src_req[PRI_FIQ] & ~fiq_off;
    qual[PRI_IRQ]  = src_req[PRI_IRQ] & ~irq_off;
    if (busy) qual = '0;
  end

  // fixed priority pick, slot 0 first
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    kind = EX_RESET;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) kind = slot_kind(i);
    end
  end

  assign take = |grant;

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(grant));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_q)
    grant[PRI_IRQ] |-> !irq_off);

  assert_fiq_masked_R6: assert property (@(posedge clk) disable iff (!rst_q)
    grant[PRI_FIQ] |-> !fiq_off);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> !take);

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0,
  parameter int              PC_AHEAD = 8
) (
  input  exc_kind_e         kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_status,
  input  logic [MODE_W-1:0] cur_mode,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [XLEN-1:0]   vec_addr,
  output logic [XLEN-1:0]   lnk_val,
  output logic [XLEN-1:0]   sav_val,
  output logic [XLEN-1:0]   sts_val,
  output logic              is_reset
);

  localparam logic [XLEN-1:0] RET_STD  = XLEN'(4) - XLEN'(PC_AHEAD);
  localparam logic [XLEN-1:0] RET_DABT = XLEN'(8) - XLEN'(PC_AHEAD);

  assign tgt_mode = kind_mode(kind);
  assign is_reset = (kind == EX_RESET);
  assign vec_addr = VEC_BASE + XLEN'({kind, 2'b00});
  assign lnk_val  = cur_pc + ((kind == EX_DABT) ? RET_DABT : RET_STD);
  assign sav_val  = {cur_status[XLEN-1:MODE_W], cur_mode};

  always_comb begin
    if (is_reset) begin
      sts_val = '0;
      sts_val[ST_F] = 1'b1;
    end else begin
      sts_val = cur_status;
      if (kind == EX_FIQ) sts_val[ST_F] = 1'b1;
    end
    sts_val[ST_I]         = 1'b1;
    sts_val[ST_T]         = 1'b0;
    sts_val[MODE_W-1:0]   = tgt_mode;
  end

endmodule

// File: rtl/exc_entry_reg.sv
module exc_entry_reg
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              take,
  input  logic              is_reset,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic [XLEN-1:0]   vec_addr,
  input  logic [XLEN-1:0]   lnk_val,
  input  logic [XLEN-1:0]   sav_val,
  input  logic [XLEN-1:0]   sts_val,
  output logic              pc_we,
  output logic              sts_we,
  output logic              sav_we,
  output logic              lnk_we,
  output logic              flush,
  output logic [MODE_W-1:0] mode_q,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   lnk_q,
  output logic [XLEN-1:0]   sav_q,
  output logic [XLEN-1:0]   sts_q
);

  logic n_pc_we, n_sts_we, n_sav_we, n_lnk_we, n_flush;

  always_comb begin
    n_pc_we  = take;
    n_sts_we = take;
    n_flush  = take;
    n_sav_we = take & ~is_reset;
    n_lnk_we = take & ~is_reset;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_we  <= 1'b0;
      sts_we <= 1'b0;
      sav_we <= 1'b0;
      lnk_we <= 1'b0;
      flush  <= 1'b0;
    end else begin
      pc_we  <= n_pc_we;
      sts_we <= n_sts_we;
      sav_we <= n_sav_we;
      lnk_we <= n_lnk_we;
      flush  <= n_flush;
    end
  end

  // payload loads only on entry
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mode_q <= MD_SVC;
      pc_q   <= '0;
      lnk_q  <= '0;
      sav_q  <= '0;
      sts_q  <= '0;
    end else if (take) begin
      mode_q <= tgt_mode;
      pc_q   <= vec_addr;
      lnk_q  <= lnk_val;
      sav_q  <= sav_val;
      sts_q  <= sts_val;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0,
  parameter int              PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rst,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_status,
  input  logic [MODE_W-1:0] cur_mode,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_data,
  output logic              sts_we,
  output logic [XLEN-1:0]   sts_data,
  output logic              sav_we,
  output logic [MODE_W-1:0] sav_mode,
  output logic [XLEN-1:0]   sav_data,
  output logic              lnk_we,
  output logic [MODE_W-1:0] lnk_mode,
  output logic [XLEN-1:0]   lnk_data,
  output logic [MODE_W-1:0] new_mode,
  output logic              flush
);

  localparam logic [XLEN-1:0] VEC_TOP = VEC_BASE + XLEN'(32);
  localparam logic [XLEN-1:0] VEC_FIQ = VEC_BASE + XLEN'(28);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [NUM_SRC-1:0] src_req;
  always_comb begin
    src_req           = '0;
    src_req[PRI_RST]  = req_rst;
    src_req[PRI_DABT] = req_dabt;
    src_req[PRI_FIQ]  = req_fiq;
    src_req[PRI_IRQ]  = req_irq;
    src_req[PRI_PABT] = req_pabt;
    src_req[PRI_UND]  = req_und;
    src_req[PRI_SWI]  = req_swi;
  end

  logic              take;
  exc_kind_e         kind;
  logic [MODE_W-1:0] tgt_mode;
  logic [XLEN-1:0]   vec_addr, lnk_val, sav_val, sts_val;
  logic              is_reset;

  exc_arbiter u_arb (
    .clk     (clk),
    .rst_q   (rst_q),
    .src_req (src_req),
    .irq_off (cur_status[ST_I]),
    .fiq_off (cur_status[ST_F]),
    .busy    (flush),
    .take    (take),
    .kind    (kind)
  );

  exc_target #(.XLEN(XLEN), .VEC_BASE(VEC_BASE), .PC_AHEAD(PC_AHEAD)) u_tgt (
    .kind       (kind),
    .cur_pc     (cur_pc),
    .cur_status (cur_status),
    .cur_mode   (cur_mode),
    .tgt_mode   (tgt_mode),
    .vec_addr   (vec_addr),
    .lnk_val    (lnk_val),
    .sav_val    (sav_val),
    .sts_val    (sts_val),
    .is_reset   (is_reset)
  );

  exc_entry_reg #(.XLEN(XLEN)) u_reg (
    .clk      (clk),
    .rst_q    (rst_q),
    .take     (take),
    .is_reset (is_reset),
    .tgt_mode (tgt_mode),
    .vec_addr (vec_addr),
    .lnk_val  (lnk_val),
    .sav_val  (sav_val),
    .sts_val  (sts_val),
    .pc_we    (pc_we),
    .sts_we   (sts_we),
    .sav_we   (sav_we),
    .lnk_we   (lnk_we),
    .flush    (flush),
    .mode_q   (new_mode),
    .pc_q     (pc_data),
    .lnk_q    (lnk_data),
    .sav_q    (sav_data),
    .sts_q    (sts_data)
  );

  assign sav_mode = new_mode;
  assign lnk_mode = new_mode;

  assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_q)
    flush |=> !flush);

  assert_vector_range_R1: assert property (@(posedge clk) disable iff (!rst_q)
    pc_we |-> (pc_data[1:0] == 2'b00) && (pc_data >= VEC_BASE) && (pc_data < VEC_TOP)
              && (pc_data != VEC_BASE + XLEN'(20)));

  assert_saved_upper_R3: assert property (@(posedge clk) disable iff (!rst_q)
    sav_we |-> sav_data[XLEN-1:MODE_W] == $past(cur_status[XLEN-1:MODE_W]));

  assert_fiq_masks_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (sts_we && pc_data == VEC_FIQ) |-> (sts_data[ST_I] && sts_data[ST_F]));

  assert_reset_nosave_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (pc_we && pc_data == VEC_BASE) |-> (!sav_we && !lnk_we));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
  logic [31:0] cur_pc, cur_status;
  logic [4:0]  cur_mode;
  logic        pc_we, sts_we, sav_we, lnk_we, flush;
  logic [31:0] pc_data, sts_data, sav_data, lnk_data;
  logic [4:0]  sav_mode, lnk_mode, new_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi), .req_pabt(req_pabt),
    .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .cur_pc(cur_pc), .cur_status(cur_status), .cur_mode(cur_mode),
    .pc_we(pc_we), .pc_data(pc_data), .sts_we(sts_we), .sts_data(sts_data),
    .sav_we(sav_we), .sav_mode(sav_mode), .sav_data(sav_data),
    .lnk_we(lnk_we), .lnk_mode(lnk_mode), .lnk_data(lnk_data),
    .new_mode(new_mode), .flush(flush)
  );

  // request vector bits: 0 rst,1 und,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  localparam int K_NONE = -1;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_req(input logic [6:0] r);
    {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und, req_rst} = r;
  endtask

  // R5/R6 model: expected vector slot index
  function automatic int exp_kind(input logic [6:0] r, input logic [31:0] st);
    if (r[0])               return 0;
    if (r[4])               return 4;
    if (r[6] && !st[6])     return 7;
    if (r[5] && !st[7])     return 6;
    if (r[3])               return 3;
    if (r[1])               return 1;
    if (r[2])               return 2;
    return K_NONE;
  endfunction

  function automatic logic [4:0] exp_mode(input int k);
    case (k)
      1:       return 5'h1B;
      3, 4:    return 5'h17;
      6:       return 5'h12;
      7:       return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  task automatic check_entry(input string req, input int k, input logic [31:0] pc,
                             input logic [31:0] st, input logic [4:0] md);
    logic [31:0] e_sts;
    if (k == K_NONE) begin
      check(req, "pc_we idle", {31'b0, pc_we}, 32'd0);
      check(req, "flush idle", {31'b0, flush}, 32'd0);
      return;
    end
    check("R1", "pc_we", {31'b0, pc_we}, 32'd1);
    check("R1", "vector", pc_data, 32'(k * 4));
    check("R2", "new_mode", {27'b0, new_mode}, {27'b0, exp_mode(k)});
    check("R9", "flush", {31'b0, flush}, 32'd1);
    check("R7", "sts_we", {31'b0, sts_we}, 32'd1);
    if (k == 0) begin
      check("R8", "sav_we", {31'b0, sav_we}, 32'd0);
      check("R8", "lnk_we", {31'b0, lnk_we}, 32'd0);
      check("R8", "sts_data", sts_data, 32'h0000_00D3);
    end else begin
      e_sts = st;
      e_sts[4:0] = exp_mode(k);
      e_sts[5] = 1'b0;
      e_sts[7] = 1'b1;
      if (k == 7) e_sts[6] = 1'b1;
      check("R7", "sts_data", sts_data, e_sts);
      check("R3", "sav_we", {31'b0, sav_we}, 32'd1);
      check("R3", "sav_mode", {27'b0, sav_mode}, {27'b0, exp_mode(k)});
      check("R3", "sav_data", sav_data, {st[31:5], md});
      check("R4", "lnk_we", {31'b0, lnk_we}, 32'd1);
      check("R4", "lnk_mode", {27'b0, lnk_mode}, {27'b0, exp_mode(k)});
      check("R4", "lnk_data", lnk_data, (k == 4) ? pc : pc - 32'd4);
    end
  endtask

  // one request pattern: drive, sample after the capturing edge, idle one cycle
  task automatic run_case(input string req, input logic [6:0] r, input logic [31:0] pc,
                          input logic [31:0] st, input logic [4:0] md);
    @(negedge clk);
    set_req(r);
    cur_pc = pc; cur_status = st; cur_mode = md;
    @(negedge clk);
    check_entry(req, exp_kind(r, st), pc, st, md);
    set_req(7'b0);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R10", "pc_we in reset", {31'b0, pc_we}, 32'd0);
    check("R10", "flush in reset", {31'b0, flush}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "pc_we", {31'b0, pc_we}, 32'd0);
    check("R10", "sav_we", {31'b0, sav_we}, 32'd0);
    check("R10", "lnk_we", {31'b0, lnk_we}, 32'd0);
    check("R10", "new_mode", {27'b0, new_mode}, 32'h13);
  endtask

  task automatic t_each_kind();
    for (int b = 0; b < 7; b++)
      run_case("R1", 7'(1 << b), 32'h0000_4008 + 32'(b * 16), 32'hA500_0030, 5'h10);
    run_case("R3", 7'b000_0010, 32'h0000_8000, 32'h5A00_0052, 5'h1F);
  endtask

  task automatic t_priority();
    run_case("R5", 7'b111_1111, 32'h100, 32'h0000_0010, 5'h10);
    run_case("R5", 7'b111_1110, 32'h200, 32'h0000_0010, 5'h10);
    run_case("R5", 7'b110_1110, 32'h300, 32'h0000_0010, 5'h10);
    run_case("R5", 7'b010_1110, 32'h400, 32'h0000_0010, 5'h10);
    run_case("R5", 7'b000_1110, 32'h500, 32'h0000_0010, 5'h10);
    run_case("R5", 7'b000_0110, 32'h600, 32'h0000_0010, 5'h10);
  endtask

  task automatic t_masking();
    run_case("R6", 7'b010_0000, 32'h700, 32'h0000_0090, 5'h10);
    run_case("R6", 7'b100_0000, 32'h800, 32'h0000_0050, 5'h10);
    run_case("R6", 7'b110_0000, 32'h900, 32'h0000_0050, 5'h10);
    run_case("R6", 7'b001_1000, 32'hA00, 32'h0000_00D0, 5'h10);
    // R7: bit 6 kept on interrupt entry
    run_case("R7", 7'b010_0000, 32'hB00, 32'h0000_0050, 5'h10);
  endtask

  task automatic t_reset_entry();
    run_case("R8", 7'b000_0001, 32'hC00, 32'hF000_0037, 5'h12);
  endtask

  task automatic t_holdoff();
    @(negedge clk);
    set_req(7'b010_0000);
    cur_pc = 32'h2000; cur_status = 32'h0000_0010; cur_mode = 5'h10;
    @(negedge clk);
    check("R9", "first entry pc_we", {31'b0, pc_we}, 32'd1);
    @(negedge clk);
    check("R9", "held request ignored", {31'b0, pc_we}, 32'd0);
    check("R9", "flush low in gap", {31'b0, flush}, 32'd0);
    check("R2", "mode held", {27'b0, new_mode}, 32'h12);
    @(negedge clk);
    check("R9", "second entry pc_we", {31'b0, pc_we}, 32'd1);
    check("R9", "second entry vector", pc_data, 32'h18);
    set_req(7'b0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    set_req(7'b0);
    cur_pc = '0; cur_status = 32'h0000_0010; cur_mode = 5'h10;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_each_kind();
    t_priority();
    t_masking();
    t_reset_entry();
    t_holdoff();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule